// File: doc/BRIEF.md
# Programmable DMA Priority Arbiter

This block chooses, in every clock cycle, which DMA requester may use a shared memory resource. It serves four numbered channels and one auxiliary channel. The auxiliary channel can be placed at any point in the fixed priority order through a small configuration register. Read transfers and write transfers are arbitrated by two independent copies of the same decision logic. A channel that is waiting for synchronization drops out of the contest, so a lower-ranked ready channel takes the grant. A channel running split transfers raises a separate second request. Both of its halves are ranked at the channel's own position.

A second stage sets the DMA winner against the CPU. Each numbered channel has a priority bit for this contest, and the auxiliary channel takes its bit from the configuration register. The grants are combinational and one-hot per direction. A configuration write takes effect in the cycle after the write strobe.

Requester index convention: indices 0 to 3 are channels 0 to 3, and index 4 is the auxiliary channel. Per-direction vectors are packed with read in bits [4:0] and write in bits [9:5].

Top module: `dmaarb_top`

## Requirements
- R1: After reset the position field is 0 and the auxiliary mode bit is 0. The order is therefore auxiliary, 0, 1, 2, 3, and the auxiliary channel yields to the CPU.
- R2: A position value p from 0 to 4 places the auxiliary channel at rank p (0 = highest). The numbered channels fill the other ranks in their own order.
- R3: Position values 5 to 15 are reserved. With any of them the auxiliary channel ranks lowest.
- R4: Among themselves, channel 0 outranks channel 1, which outranks 2, which outranks 3.
- R5: A request whose wait flag is set is not eligible. The highest-ranked eligible request wins, and when the wait flag clears the channel wins back over lower-ranked channels.
- R6: When a channel's split flag is 1, its second (receive) request competes at the channel's rank, just below its main (transmit) request and above every lower-ranked channel. When the split flag is 0 the second request is ignored.
- R7: Read and write arbitration use separate inputs and outputs and do not affect each other.
- R8: The DMA winner competes with the CPU request of the same direction. If the winner's priority bit is 0 and the CPU requests, only the CPU is granted. If the bit is 1, only the DMA winner is granted. The bits are ch_dma_pri[c] for channel c and configuration bit 4 for the auxiliary channel.
- R9: With no eligible DMA request, the CPU is granted exactly when it requests.
- R10: Per direction at most one grant (main, second or CPU) is high, and none is high when nothing eligible is requesting.
- R11: The configuration register loads cfg_wdata (bits 3:0 position, bit 4 auxiliary mode) only on a clock edge with cfg_we high. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Bits 3:0 auxiliary position, bit 4 auxiliary DMA-over-CPU mode |
| ch_dma_pri | input | 4 | Per numbered channel: 1 = DMA beats CPU, 0 = CPU beats DMA |
| split_en | input | 5 | Per requester split-transfer flag |
| req_main | input | 10 | Main (transmit) requests, read in [4:0], write in [9:5] |
| wait_main | input | 10 | Main request waiting for synchronization |
| req_sub | input | 10 | Second (receive) requests of split channels |
| wait_sub | input | 10 | Second request waiting for synchronization |
| cpu_req | input | 2 | CPU request, bit 0 read, bit 1 write |
| gnt_main | output | 10 | One-hot main grants |
| gnt_sub | output | 10 | One-hot second-request grants |
| cpu_gnt | output | 2 | CPU grant per direction |

## Verification
On every cycle the assertions check the following:
- each direction holds at most one grant;
- a grant never goes to a waiting, absent or non-split request;
- the CPU is granted only when it requests, and always when no DMA request is eligible;
- the configuration register changes only after a write strobe.

The actual rank order cannot be seen from such local invariants, so it is shown only by the bench's scenarios. That covers:
- where the auxiliary channel lands for each position value, including the reserved ones;
- the transmit-over-receive ordering of split halves;
- regaining the grant when a wait clears;
- which side wins the CPU contest under each priority bit.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
   localparam int CFG_W = 5;
   localparam int POS_W = 4;

   typedef struct packed {
      logic             aux_dma;
      logic [POS_W-1:0] aux_pos;
   } dmaarb_cfg_t;
endpackage

// File: rtl/dmaarb_cfg_reg.sv
module dmaarb_cfg_reg
   import dmaarb_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [CFG_W-1:0]    wdata,
   output dmaarb_cfg_t         cfg_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we) begin
         cfg_q <= dmaarb_cfg_t'(wdata);
      end
   end
endmodule

// File: rtl/dmaarb_rank.sv
module dmaarb_rank
   import dmaarb_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int NREQ   = NUM_CH + 1,
   localparam int RANK_W = $clog2(NREQ)
) (
   input  logic [POS_W-1:0]             aux_pos,
   output logic [NREQ-1:0][RANK_W-1:0]  rank
);
   localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(NUM_CH);
   localparam logic [RANK_W-1:0] LAST_RANK = RANK_W'(NUM_CH);

   logic [RANK_W-1:0] aux_slot;

   always_comb begin
      if (aux_pos > LAST_POS) aux_slot = LAST_RANK;
      else                    aux_slot = RANK_W'(aux_pos);
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_comb begin
         if (aux_slot <= RANK_W'(c)) rank[c] = RANK_W'(c + 1);
         else                        rank[c] = RANK_W'(c);
      end
   end

   assign rank[NUM_CH] = aux_slot;
endmodule

// File: rtl/dmaarb_stage.sv
module dmaarb_stage #(
   parameter int NUM_CH = 4,
   localparam int NREQ   = NUM_CH + 1,
   localparam int RANK_W = $clog2(NREQ),
   localparam int KEY_W  = RANK_W + 1
) (
   input  logic [NREQ-1:0][RANK_W-1:0] rank,
   input  logic [NREQ-1:0]             elig_main,
   input  logic [NREQ-1:0]             elig_sub,
   input  logic [NREQ-1:0]             dma_pri,
   input  logic                        cpu_req,
   output logic [NREQ-1:0]             gnt_main,
   output logic [NREQ-1:0]             gnt_sub,
   output logic                        cpu_gnt
);
   logic              found;
   logic              win_sub;
   logic [RANK_W-1:0] win_r;
   logic [KEY_W-1:0]  best;
   logic              dma_wins;

   always_comb begin
      found   = 1'b0;
      win_sub = 1'b0;
      win_r   = '0;
      best    = '1;
      for (int r = 0; r < NREQ; r++) begin
         if (elig_main[r] && (!found || {rank[r], 1'b0} < best)) begin
            found   = 1'b1;
            best    = {rank[r], 1'b0};
            win_r   = RANK_W'(r);
            win_sub = 1'b0;
         end
         if (elig_sub[r] && (!found || {rank[r], 1'b1} < best)) begin
            found   = 1'b1;
            best    = {rank[r], 1'b1};
            win_r   = RANK_W'(r);
            win_sub = 1'b1;
         end
      end
   end

   assign dma_wins = found && (!cpu_req || dma_pri[win_r]);
   assign cpu_gnt  = cpu_req && !dma_wins;

   always_comb begin
      gnt_main = '0;
      gnt_sub  = '0;
      if (dma_wins) begin
         if (win_sub) gnt_sub[win_r]  = 1'b1;
         else         gnt_main[win_r] = 1'b1;
      end
   end
endmodule

// File: rtl/dmaarb_top.sv
module dmaarb_top
   import dmaarb_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int NREQ   = NUM_CH + 1,
   localparam int NDIR   = 2,
   localparam int RANK_W = $clog2(NREQ)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [CFG_W-1:0]       cfg_wdata,
   input  logic [NUM_CH-1:0]      ch_dma_pri,
   input  logic [NREQ-1:0]        split_en,
   input  logic [NDIR*NREQ-1:0]   req_main,
   input  logic [NDIR*NREQ-1:0]   wait_main,
   input  logic [NDIR*NREQ-1:0]   req_sub,
   input  logic [NDIR*NREQ-1:0]   wait_sub,
   input  logic [NDIR-1:0]        cpu_req,
   output logic [NDIR*NREQ-1:0]   gnt_main,
   output logic [NDIR*NREQ-1:0]   gnt_sub,
   output logic [NDIR-1:0]        cpu_gnt
);
   if (NUM_CH < 1 || NUM_CH >= (1 << POS_W)) begin : g_bad_num_ch
      $error("dmaarb_top: NUM_CH out of range for the position field");
   end

   dmaarb_cfg_t                cfg_q;
   logic [NREQ-1:0][RANK_W-1:0] rank;
   logic [NREQ-1:0]             dma_pri;

   dmaarb_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .cfg_q (cfg_q)
   );

   dmaarb_rank #(.NUM_CH(NUM_CH)) u_rank (
      .aux_pos (cfg_q.aux_pos),
      .rank    (rank)
   );

   assign dma_pri = {cfg_q.aux_dma, ch_dma_pri};

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      logic [NREQ-1:0] elig_main;
      logic [NREQ-1:0] elig_sub;

      assign elig_main = req_main[d*NREQ +: NREQ] & ~wait_main[d*NREQ +: NREQ];
      assign elig_sub  = split_en & req_sub[d*NREQ +: NREQ] & ~wait_sub[d*NREQ +: NREQ];

      dmaarb_stage #(.NUM_CH(NUM_CH)) u_stage (
         .rank      (rank),
         .elig_main (elig_main),
         .elig_sub  (elig_sub),
         .dma_pri   (dma_pri),
         .cpu_req   (cpu_req[d]),
         .gnt_main  (gnt_main[d*NREQ +: NREQ]),
         .gnt_sub   (gnt_sub[d*NREQ +: NREQ]),
         .cpu_gnt   (cpu_gnt[d])
      );
   end
endmodule

// File: rtl/dmaarb_chk.sv
module dmaarb_chk
   import dmaarb_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int NREQ = NUM_CH + 1,
   localparam int NDIR = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_we,
   input logic [CFG_W-1:0]     cfg_q,
   input logic [NREQ-1:0]      split_en,
   input logic [NDIR*NREQ-1:0] req_main,
   input logic [NDIR*NREQ-1:0] wait_main,
   input logic [NDIR*NREQ-1:0] req_sub,
   input logic [NDIR*NREQ-1:0] wait_sub,
   input logic [NDIR-1:0]      cpu_req,
   input logic [NDIR*NREQ-1:0] gnt_main,
   input logic [NDIR*NREQ-1:0] gnt_sub,
   input logic [NDIR-1:0]      cpu_gnt
);
   assert_main_elig_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_main & ~(req_main & ~wait_main)) == '0);

   assert_sub_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_sub & ~({NDIR{split_en}} & req_sub & ~wait_sub)) == '0);

   assert_cpu_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_gnt & ~cpu_req) == '0);

   assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_we) |-> $stable(cfg_q));

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      logic any_elig;
      assign any_elig = |((req_main[d*NREQ +: NREQ] & ~wait_main[d*NREQ +: NREQ]) |
                          (split_en & req_sub[d*NREQ +: NREQ] & ~wait_sub[d*NREQ +: NREQ]));

      assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0({gnt_main[d*NREQ +: NREQ], gnt_sub[d*NREQ +: NREQ], cpu_gnt[d]}));

      assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (!any_elig && !cpu_req[d]) |->
            ({gnt_main[d*NREQ +: NREQ], gnt_sub[d*NREQ +: NREQ], cpu_gnt[d]} == '0));

      assert_cpu_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (!any_elig && cpu_req[d]) |-> cpu_gnt[d]);
   end
endmodule

bind dmaarb_top dmaarb_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_q     (cfg_q),
   .split_en  (split_en),
   .req_main  (req_main),
   .wait_main (wait_main),
   .req_sub   (req_sub),
   .wait_sub  (wait_sub),
   .cpu_req   (cpu_req),
   .gnt_main  (gnt_main),
   .gnt_sub   (gnt_sub),
   .cpu_gnt   (cpu_gnt)
);

// File: tb/sim_dmaarb_top.sv
module sim_dmaarb_top;
   localparam int NUM_CH = 4;
   localparam int NREQ   = NUM_CH + 1;
   localparam int AUX    = NUM_CH;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [4:0]      cfg_wdata = '0;
   logic [3:0]      ch_dma_pri = '0;
   logic [4:0]      split_en = '0;
   logic [9:0]      req_main = '0;
   logic [9:0]      wait_main = '0;
   logic [9:0]      req_sub = '0;
   logic [9:0]      wait_sub = '0;
   logic [1:0]      cpu_req = '0;
   logic [9:0]      gnt_main;
   logic [9:0]      gnt_sub;
   logic [1:0]      cpu_gnt;

   int n_vec = 0;
   int n_bad = 0;
   int m_field = 0;
   logic m_mode = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dmaarb_top #(.NUM_CH(NUM_CH)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .ch_dma_pri(ch_dma_pri), .split_en(split_en),
      .req_main(req_main), .wait_main(wait_main),
      .req_sub(req_sub), .wait_sub(wait_sub), .cpu_req(cpu_req),
      .gnt_main(gnt_main), .gnt_sub(gnt_sub), .cpu_gnt(cpu_gnt)
   );

   function automatic void model(input int d, output logic [NREQ-1:0] gm,
                                 output logic [NREQ-1:0] gs, output logic gc);
      int order[$];
      int pos;
      int win = -1;
      bit sub = 0;
      logic wbit;
      gm = '0; gs = '0; gc = 1'b0;
      for (int c = 0; c < NUM_CH; c++) order.push_back(c);
      pos = (m_field > NUM_CH) ? NUM_CH : m_field;
      order.insert(pos, AUX);
      foreach (order[i]) begin
         if (win < 0) begin
            int r = order[i];
            if (req_main[d*NREQ+r] && !wait_main[d*NREQ+r]) begin
               win = r; sub = 0;
            end else if (split_en[r] && req_sub[d*NREQ+r] && !wait_sub[d*NREQ+r]) begin
               win = r; sub = 1;
            end
         end
      end
      wbit = 1'b0;
      if (win == AUX) wbit = m_mode;
      else if (win >= 0) wbit = ch_dma_pri[win];
      if (win >= 0 && (!cpu_req[d] || wbit)) begin
         if (sub) gs[win] = 1'b1;
         else     gm[win] = 1'b1;
      end else begin
         gc = cpu_req[d];
      end
   endfunction

   task automatic compare(input string tag);
      logic [NREQ-1:0] gm0, gs0, gm1, gs1;
      logic gc0, gc1;
      logic [21:0] exp_v, act_v;
      model(0, gm0, gs0, gc0);
      model(1, gm1, gs1, gc1);
      exp_v = {gc1, gc0, gs1, gs0, gm1, gm0};
      act_v = {cpu_gnt, gnt_sub, gnt_main};
      n_vec++;
      if (act_v !== exp_v) begin
         n_bad++;
         $display("FAIL %s: cpu/sub/main grants actual %b expected %b", tag, act_v, exp_v);
      end
   endtask

   task automatic cycle(input string tag);
      @(negedge clk);
      compare(tag);
      @(posedge clk);
      if (cfg_we && rst_n) begin
         m_field = int'(cfg_wdata[3:0]);
         m_mode  = cfg_wdata[4];
      end
      #2;
      cfg_we = 1'b0;
   endtask

   task automatic write_cfg(input int pos, input logic mode, input string tag);
      cfg_we = 1'b1;
      cfg_wdata = {mode, 4'(pos)};
      cycle(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1: reset order, aux first and yielding to CPU
      req_main = '1;
      cycle("R1");
      @(negedge clk);
      n_vec++;
      if (gnt_main !== 10'b10000_10000) begin
         n_bad++;
         $display("FAIL R1: gnt_main actual %b expected %b", gnt_main, 10'b10000_10000);
      end
      cpu_req = 2'b11;
      cycle("R1");
      cpu_req = '0;
      // R2: every legal position, all requesting and aux with one channel
      for (int p = 0; p <= NUM_CH; p++) begin
         write_cfg(p, 1'b1, "R2");
         req_main = '1;
         cycle("R2");
         req_main = 10'b10100_10001;
         cycle("R2");
         req_main = 10'b11000_10010;
         cycle("R2");
      end
      // R3: reserved positions place aux last
      for (int p = 5; p < 16; p += 5) begin
         write_cfg(p, 1'b0, "R3");
         req_main = 10'b11000_11000;
         cycle("R3");
         req_main = 10'b10000_10000;
         cycle("R3");
      end
      write_cfg(15, 1'b0, "R3");
      req_main = 10'b10000_11000;
      cycle("R3");
      // R4: numbered channel order
      write_cfg(2, 1'b0, "R4");
      req_main = 10'b01110_01100;
      cycle("R4");
      req_main = 10'b01000_00110;
      cycle("R4");
      // R5: wait masks and regain
      req_main = 10'b00011_00011;
      wait_main = 10'b00001_00001;
      cycle("R5");
      wait_main = '0;
      cycle("R5");
      wait_main = 10'b00011_00000;
      cycle("R5");
      wait_main = '0;
      // R6: split halves
      split_en = 5'b00010;
      req_main = 10'b00100_00000;
      req_sub  = 10'b00010_00010;
      cycle("R6");
      req_main = 10'b00010_00100;
      cycle("R6");
      wait_main = 10'b00010_00000;
      cycle("R6");
      wait_sub = 10'b00010_00000;
      cycle("R6");
      split_en = '0;
      cycle("R6");
      wait_main = '0; wait_sub = '0; req_sub = '0;
      // R7: independent directions
      req_main = 10'b00001_01000;
      cpu_req = 2'b01;
      ch_dma_pri = 4'b0001;
      cycle("R7");
      // R8: CPU contest
      ch_dma_pri = 4'b0000;
      req_main = 10'b00001_00001;
      cpu_req = 2'b11;
      cycle("R8");
      ch_dma_pri = 4'b0001;
      cycle("R8");
      write_cfg(0, 1'b1, "R8");
      req_main = 10'b10000_10000;
      cycle("R8");
      write_cfg(0, 1'b0, "R8");
      cycle("R8");
      // R9 and R10: nothing eligible
      req_main = 10'b00100_00100;
      wait_main = 10'b00100_00100;
      cpu_req = 2'b01;
      cycle("R9");
      cpu_req = '0;
      cycle("R10");
      wait_main = '0; req_main = '0;
      cycle("R10");
      // R11: data without strobe is ignored
      req_main = 10'b10001_10001;
      cfg_wdata = 5'b0_0100;
      cycle("R11");
      cycle("R11");
      // R10: random traffic with occasional reconfiguration
      for (int i = 0; i < 400; i++) begin
         req_main   = 10'($urandom);
         wait_main  = 10'($urandom) & 10'($urandom);
         req_sub    = 10'($urandom);
         wait_sub   = 10'($urandom) & 10'($urandom);
         split_en   = 5'($urandom);
         cpu_req    = 2'($urandom);
         ch_dma_pri = 4'($urandom);
         cfg_wdata  = 5'($urandom);
         cfg_we     = (($urandom % 8) == 0);
         cycle("R10");
      end
      finish_run();
   end
endmodule